// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block models a synchronous static memory with a flow-through read path and a four-beat burst counter. On each rising clock edge it registers its control, address and write-data inputs. An access starts when one of two address strobes is low. From then on a step input moves the burst through the four words of an aligned group. The order is either linear (wrapping count) or interleaved (start offset XOR count), chosen by a mode input that is captured with the start address.

Reads are flow-through. Once an address is registered, the stored word and its per-lane parity bits appear combinationally on the read outputs in the following cycle. They are qualified by a bus-drive flag that follows the output-enable input. Writes go byte lane by byte lane: a lane-write enable qualifies active-low lane selects, and a global write input overrides them and writes every lane. Each lane carries eight data bits and one parity bit.

A doze input puts the device to sleep and wakes it again, with two clock edges of latency in each direction. While asleep the device ignores every access and does not drive the bus. The device-edge bus is split into separate write-data and read-data ports plus a drive flag, so a pad wrapper can build the shared bidirectional bus.

Top module: `flowsram_top`

## Requirements
- R1: An address is loaded at a clock edge only when strobe A (`strobeAN`) or strobe B (`strobeBN`) is low and `en0N`=0, `en1`=1 and `en2N`=0. A low strobe A is ignored while `en0N` is high: it neither loads nor deselects, and the burst in progress continues.
- R2: A low strobe B while any chip enable is inactive deselects the device, and `busOe` is 0 from the next cycle. A low strobe A with `en0N` low and another enable inactive also deselects.
- R3: With `interleave`=0 captured at load, the low two address bits are (start + count) mod 4. The count is cleared at load and incremented at each edge where `stepN` is low and no strobe is active. With `stepN` high the address holds.
- R4: With `interleave`=1 captured at load, the low two address bits are start XOR count. The upper address bits never change during a burst.
- R5: A write is started by strobe B only when strobe A is high. When both strobes are low, the cycle is a read and the memory is unchanged.
- R6: With `allWrN`=1 and `laneWrN`=0, each lane i whose `laneSelN[i]` is 0 writes `wrData[8i+7:8i]` and parity `wrPar[i]`. Lanes whose select is 1 keep their old contents. Any mix of lanes is allowed.
- R7: With `allWrN`=1, the cycle is a read if `laneWrN`=1, or if `laneWrN`=0 and every `laneSelN` bit is 1. A read leaves the memory unchanged.
- R8: With `allWrN`=0, every lane is written, whatever `laneWrN` and `laneSelN` are.
- R9: After an edge that registers or steps an address, `rdData`/`rdPar` show the word stored at that address (flow-through). Continuation cycles of an active burst write to the stepped address.
- R10: `busOe` is 1 only while `oeN` is 0, the device is selected and it is awake. While `busOe` is 0, `rdData` and `rdPar` are 0.
- R11: If `doze` is first sampled high at edge k, accesses at edges k and k+1 still complete. From edge k+2 onward accesses are ignored and `busOe` is 0. Once `doze` is sampled low at edge m, the device serves accesses again from edge m+2.
- R12: After reset the device is deselected and awake, and `busOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| strobeAN | input | 1 | Address strobe A, active low, gated by en0N |
| strobeBN | input | 1 | Address strobe B, active low, may start writes |
| stepN | input | 1 | Burst advance, active low |
| en0N | input | 1 | Chip enable 0, active low |
| en1 | input | 1 | Chip enable 1, active high |
| en2N | input | 1 | Chip enable 2, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| allWrN | input | 1 | Global write, active low |
| laneWrN | input | 1 | Lane-write qualifier, active low |
| laneSelN | input | LANES | Per-lane select, active low |
| oeN | input | 1 | Output enable, active low |
| doze | input | 1 | Sleep request, active high |
| wrData | input | LANES*8 | Write data, lane i in bits 8i+7:8i |
| wrPar | input | LANES | Write parity, bit i for lane i |
| rdData | output | LANES*8 | Read data (0 when not driving) |
| rdPar | output | LANES | Read parity (0 when not driving) |
| busOe | output | 1 | High while the read outputs drive the bus |

## Verification
Writes, address loads and burst steps take effect at the edge that samples them. Read data for that address is due in the same cycle after the edge, because the read path has no output register. `busOe` follows `oeN` with no delay, while doze changes take effect two edges after they are sampled. The bench changes inputs only on the falling edge and updates its reference model right after each rising edge. It compares `busOe`, `rdData` and `rdPar` against that model at the next falling edge, so every result is sampled in the cycle in which it becomes due. Directed sequences check the burst orders, lane masks and doze timing against an address-derived fill pattern rather than against the model.

// File: rtl/flowsram_pkg.sv
package flowsram_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // register a new start address
    logic stepBurst;  // advance the burst count
    logic wrEn;       // this cycle writes
    logic wrAll;      // write every lane
  } ctlStrobes_t;

  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burstOrder_e;

  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] count,
                                          input burstOrder_e order);
    return (order == BURST_INTERLEAVE) ? (start ^ count) : (start + count);
  endfunction

endpackage

// File: rtl/flowsram_ctl.sv
module flowsram_ctl
  import flowsram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobeAN,
  input  logic             strobeBN,
  input  logic             stepN,
  input  logic             en0N,
  input  logic             en1,
  input  logic             en2N,
  input  logic             allWrN,
  input  logic             laneWrN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             doze,
  output ctlStrobes_t      str,
  output logic             active,
  output logic             asleep
);

  logic [1:0] dozePipe;
  logic       activeQ;
  logic       nextActive;
  logic       chipSel;
  logic       startA;
  logic       startB;
  logic       anyLane;

  assign chipSel = !en0N && en1 && !en2N;
  assign startA  = !strobeAN && !en0N;   // strobe A gated by enable 0
  assign startB  = !strobeBN;
  assign anyLane = !allWrN || (!laneWrN && !(&laneSelN));
  assign asleep  = dozePipe[1];
  assign active  = activeQ;

  always_comb begin
    str        = '0;
    str.wrAll  = !allWrN;
    nextActive = activeQ;
    if (!asleep) begin
      if (startA || startB) begin
        if (chipSel) begin
          str.loadAddr = 1'b1;
          nextActive   = 1'b1;
          str.wrEn     = startB && strobeAN && anyLane;
        end else begin
          nextActive = 1'b0;
        end
      end else if (activeQ) begin
        str.stepBurst = !stepN;
        str.wrEn      = anyLane;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dozePipe <= '0;
      activeQ  <= 1'b0;
    end else begin
      dozePipe <= {dozePipe[0], doze};
      activeQ  <= nextActive;
    end
  end

endmodule

// File: rtl/flowsram_dp.sv
module flowsram_dp
  import flowsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             str,
  input  logic                    interleave,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        laneSelN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        wrPar,
  input  logic                    oeN,
  input  logic                    active,
  input  logic                    asleep,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic [LANES-1:0]        rdPar,
  output logic                    busOe,
  output logic [ADDR_W-1:0]       effAddr
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] baseQ, nextBase;
  logic [1:0]        countQ, nextCount;
  burstOrder_e       orderQ, nextOrder;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  laneMask;

  function automatic logic [ADDR_W-1:0] effOf(input logic [ADDR_W-1:0] base,
                                               input logic [1:0] count,
                                               input burstOrder_e order);
    return {base[ADDR_W-1:2], burstLow(base[1:0], count, order)};
  endfunction

  always_comb begin
    nextBase  = baseQ;
    nextCount = countQ;
    nextOrder = orderQ;
    if (str.loadAddr) begin
      nextBase  = addr;
      nextCount = 2'd0;
      nextOrder = burstOrder_e'(interleave);
    end else if (str.stepBurst) begin
      nextCount = countQ + 2'd1;
    end
  end

  assign wrAddr  = effOf(nextBase, nextCount, nextOrder);
  assign effAddr = effOf(baseQ, countQ, orderQ);
  assign busOe   = !oeN && active && !asleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      countQ <= '0;
      orderQ <= BURST_LINEAR;
    end else begin
      baseQ  <= nextBase;
      countQ <= nextCount;
      orderQ <= nextOrder;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W:0] laneMem [DEPTH];
    logic [LANE_W:0] laneRd;

    assign laneMask[g] = str.wrEn && (str.wrAll || !laneSelN[g]);

    always_ff @(posedge clk) begin
      if (laneMask[g]) laneMem[wrAddr] <= {wrPar[g], wrData[g*LANE_W +: LANE_W]};
    end

    assign laneRd = laneMem[effAddr];
    assign rdData[g*LANE_W +: LANE_W] = busOe ? laneRd[LANE_W-1:0] : '0;
    assign rdPar[g] = busOe ? laneRd[LANE_W] : 1'b0;
  end

endmodule

// File: rtl/flowsram_top.sv
module flowsram_top
  import flowsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobeAN,
  input  logic                    strobeBN,
  input  logic                    stepN,
  input  logic                    en0N,
  input  logic                    en1,
  input  logic                    en2N,
  input  logic                    interleave,
  input  logic                    allWrN,
  input  logic                    laneWrN,
  input  logic [LANES-1:0]        laneSelN,
  input  logic                    oeN,
  input  logic                    doze,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        wrPar,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic [LANES-1:0]        rdPar,
  output logic                    busOe
);

  ctlStrobes_t       ctlStr;
  logic              active;
  logic              asleep;
  logic [ADDR_W-1:0] effAddr;

  flowsram_ctl #(.LANES(LANES)) ctl_i (
    .clk(clk), .rstN(rstN), .strobeAN(strobeAN), .strobeBN(strobeBN),
    .stepN(stepN), .en0N(en0N), .en1(en1), .en2N(en2N), .allWrN(allWrN),
    .laneWrN(laneWrN), .laneSelN(laneSelN), .doze(doze),
    .str(ctlStr), .active(active), .asleep(asleep)
  );

  flowsram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .str(ctlStr), .interleave(interleave),
    .addr(addr), .laneSelN(laneSelN), .wrData(wrData), .wrPar(wrPar),
    .oeN(oeN), .active(active), .asleep(asleep), .rdData(rdData),
    .rdPar(rdPar), .busOe(busOe), .effAddr(effAddr)
  );

endmodule

// File: rtl/flowsram_chk.sv
module flowsram_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              strobeAN,
  input logic              strobeBN,
  input logic              stepN,
  input logic              en0N,
  input logic              en1,
  input logic              en2N,
  input logic              oeN,
  input logic              doze,
  input logic              busOe,
  input logic [ADDR_W-1:0] effAddr,
  input logic              wrEn
);

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !busOe);

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeBN && (en0N || !en1 || en2N) && !$past(doze, 2)) |=> !busOe);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobeAN && strobeBN && stepN) |=> $stable(effAddr));

  assert_ignore_a_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeAN && en0N && strobeBN && stepN) |=> $stable(effAddr));

  assert_both_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeAN && !strobeBN && !en0N) |-> !wrEn);

  assert_doze_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(doze) && $past(doze, 2)) |-> !busOe);

endmodule

bind flowsram_top flowsram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .strobeAN(strobeAN), .strobeBN(strobeBN),
  .stepN(stepN), .en0N(en0N), .en1(en1), .en2N(en2N), .oeN(oeN),
  .doze(doze), .busOe(busOe), .effAddr(effAddr), .wrEn(ctlStr.wrEn)
);

// File: tb/flowsram_top_tb_top.sv
module flowsram_top_tb_top;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr;
  logic strobeAN, strobeBN, stepN, en0N, en1, en2N, interleave;
  logic allWrN, laneWrN, oeN, doze;
  logic [LN-1:0] laneSelN, wrPar, rdPar;
  logic [LN*8-1:0] wrData, rdData;
  logic busOe;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flowsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .strobeAN(strobeAN),
    .strobeBN(strobeBN), .stepN(stepN), .en0N(en0N), .en1(en1),
    .en2N(en2N), .interleave(interleave), .allWrN(allWrN),
    .laneWrN(laneWrN), .laneSelN(laneSelN), .oeN(oeN), .doze(doze),
    .wrData(wrData), .wrPar(wrPar), .rdData(rdData), .rdPar(rdPar),
    .busOe(busOe)
  );

  // reference state
  logic [LN*8-1:0] refD [DEPTH];
  logic [LN-1:0]   refP [DEPTH];
  logic [AW-1:0]   rBase = '0;
  logic [1:0]      rCnt = '0;
  logic            rMode = 1'b0, rAct = 1'b0, rDz0 = 1'b0, rSleep = 1'b0;

  function automatic logic [LN*8-1:0] patD(input int a);
    logic [LN*8-1:0] v;
    for (int i = 0; i < LN; i++) v[i*8 +: 8] = 8'((a * 4 + i) ^ 8'h5A);
    return v;
  endfunction

  function automatic logic [LN-1:0] patP(input int a);
    logic [LN-1:0] v;
    for (int i = 0; i < LN; i++) v[i] = 1'(a ^ i);
    return v;
  endfunction

  function automatic logic [AW-1:0] refEff();
    logic [1:0] lo;
    lo = rMode ? (rBase[1:0] ^ rCnt) : (rBase[1:0] + rCnt);
    return {rBase[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit chip, sA, sB, anyLane, wr;
    logic [AW-1:0] e;
    chip = !en0N && en1 && !en2N;
    sA = !strobeAN && !en0N;
    sB = !strobeBN;
    anyLane = !allWrN || (!laneWrN && !(&laneSelN));
    wr = 0;
    if (!rSleep) begin
      if (sA || sB) begin
        if (chip) begin
          rBase = addr; rCnt = 2'd0; rMode = interleave; rAct = 1'b1;
          wr = sB && strobeAN && anyLane;
        end else rAct = 1'b0;
      end else if (rAct) begin
        if (!stepN) rCnt = rCnt + 2'd1;
        wr = anyLane;
      end
    end
    if (wr) begin
      e = refEff();
      for (int i = 0; i < LN; i++)
        if (!allWrN || !laneSelN[i]) begin
          refD[e][i*8 +: 8] = wrData[i*8 +: 8];
          refP[e][i] = wrPar[i];
        end
    end
    rSleep = rDz0;
    rDz0 = doze;
  endtask

  // one clock: model at rising edge, compare at falling edge (R9, R10)
  task automatic tick();
    logic expOe;
    logic [AW-1:0] e;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    expOe = !oeN && rAct && !rSleep;
    chk("R9/R10 busOe", 64'(busOe), 64'(expOe));
    e = refEff();
    if (expOe) chk("R9 read word", {28'd0, rdPar, rdData}, {28'd0, refP[e], refD[e]});
    else chk("R10 idle bus", {28'd0, rdPar, rdData}, 64'd0);
  endtask

  task automatic idle();
    strobeAN = 1; strobeBN = 1; stepN = 1; en0N = 0; en1 = 1; en2N = 0;
    interleave = 0; allWrN = 1; laneWrN = 1; laneSelN = '1; oeN = 0;
    doze = 0; wrData = '0; wrPar = '0; addr = '0;
  endtask

  task automatic loadRead(input int a, input logic mode);
    idle(); strobeBN = 0; addr = AW'(a); interleave = mode; tick();
  endtask

  task automatic expWord(input string tag, input int a);
    chk(tag, {28'd0, rdPar, rdData}, {28'd0, patP(a), patD(a)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R12 reset busOe", 64'(busOe), 64'd0);

    // fill every word with the address pattern (R8 global write)
    for (int a = 0; a < DEPTH; a++) begin
      idle(); strobeBN = 0; addr = AW'(a); allWrN = 0; oeN = 1;
      wrData = patD(a); wrPar = patP(a); tick();
    end

    // R3 linear burst 13 -> 14,15,12 and hold
    loadRead(13, 0); expWord("R3 start", 13);
    idle(); stepN = 0; tick(); expWord("R3 step1", 14);
    tick(); expWord("R3 step2", 15);
    tick(); expWord("R3 wrap", 12);
    idle(); tick(); expWord("R3 hold", 12);

    // R4 interleaved burst 13 -> 12,15,14
    loadRead(13, 1);
    idle(); stepN = 0; tick(); expWord("R4 step1", 12);
    tick(); expWord("R4 step2", 15);
    tick(); expWord("R4 step3", 14);

    // R1 strobe A ignored with en0N high: burst continues
    loadRead(20, 0);
    idle(); strobeAN = 0; en0N = 1; addr = 6'd33; stepN = 0; tick();
    expWord("R1 ignored strobe A", 21);

    // R2 deselect via strobe B with en1 low
    idle(); strobeBN = 0; en1 = 0; tick();
    chk("R2 deselected", 64'(busOe), 64'd0);
    loadRead(20, 0);
    idle(); strobeAN = 0; en2N = 1; tick();
    chk("R2 deselect A", 64'(busOe), 64'd0);

    // R5 both strobes low with write inputs -> read
    idle(); strobeAN = 0; strobeBN = 0; addr = 6'd31; allWrN = 0;
    wrData = '1; wrPar = '1; tick();
    expWord("R5 no write", 31);

    // R6 lanes 0 and 2 written
    idle(); strobeBN = 0; addr = 6'd40; laneWrN = 0; laneSelN = 4'b1010;
    wrData = 32'hA1B2C3D4; wrPar = 4'b1111; oeN = 1; tick();
    idle(); tick();
    chk("R6 lane mask", {28'd0, rdPar, rdData},
        {28'd0, patP(40) | 4'b0101,
         patD(40)[31:24], 8'hB2, patD(40)[15:8], 8'hD4});

    // R7 reads: laneWrN high, then all selects high
    idle(); strobeBN = 0; addr = 6'd41; laneSelN = 4'b0000; wrData = '1; tick();
    expWord("R7 laneWrN high", 41);
    idle(); strobeBN = 0; addr = 6'd41; laneWrN = 0; wrData = '1; tick();
    expWord("R7 no lane", 41);

    // R8 global write ignores selects
    idle(); strobeBN = 0; addr = 6'd42; allWrN = 0; wrData = 32'h0BADF00D;
    wrPar = 4'b0110; oeN = 1; tick();
    idle(); tick();
    chk("R8 all lanes", {28'd0, rdPar, rdData}, {28'd0, 4'b0110, 32'h0BADF00D});

    // R10 oe high
    idle(); oeN = 1; tick();
    chk("R10 oe high", 64'(busOe), 64'd0);

    // R11 doze timing
    loadRead(9, 0);
    idle(); doze = 1; tick();
    chk("R11 still awake k", 64'(busOe), 64'd1);
    tick();
    chk("R11 asleep k+1", 64'(busOe), 64'd0);
    idle(); doze = 1; strobeBN = 0; addr = 6'd22; allWrN = 0; wrData = '0; tick();
    chk("R11 access ignored", 64'(busOe), 64'd0);
    idle(); tick();
    chk("R11 waking m", 64'(busOe), 64'd0);
    tick();
    chk("R11 awake m+1", 64'(busOe), 64'd1);
    expWord("R11 address kept", 9);
    idle(); strobeBN = 0; addr = 6'd22; tick();
    expWord("R11 ignored write", 22);

    // constrained random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      idle();
      addr = AW'($urandom);
      strobeAN = ($urandom % 4) != 0;
      strobeBN = ($urandom % 3) != 0;
      stepN = $urandom % 2;
      en0N = ($urandom % 10) == 0;
      en1 = ($urandom % 10) != 0;
      en2N = ($urandom % 10) == 0;
      interleave = $urandom % 2;
      allWrN = ($urandom % 5) != 0;
      laneWrN = $urandom % 2;
      laneSelN = LN'($urandom);
      oeN = ($urandom % 6) == 0;
      doze = ((n / 97) % 5) == 4;
      wrData = $urandom;
      wrPar = LN'($urandom);
      tick();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule